// File: doc/BRIEF.md
# Two-Band Receiver Scan Sequencer

This block steps the sector commutator of a warning receiver through its angular sectors and alternates the receiver between two frequency bands. The commutator moves on an external sector-clock enable, nominally 12.5 kHz. An empty sector is left on the first such tick. An occupied sector is held until the downstream processing, including PRF measurement, reports completion.

After a configurable number of complete sector sweeps, the sequencer changes band. Each band change starts a hold-off pulse of fixed length, 40 ms by default. During that pulse the pulse and CW detector inputs are gated off, hemisphere analysis is blocked, both band blocks are raised, and the commutator is frozen so that analog transients can settle. When automatic band control is not available, the band follows a manual command from the control panel instead. A radar blanking input forces both band blocks high at once, whatever the scan is doing.

The hold-off length is a parameter derived from the clock frequency. The sector count is also a parameter.

Top module: `band_scan_seq`

## Requirements
- R1: While reset is high, band I is enabled (band1_en=1, band2_en=0), sector_idx is 0, and the hold-off is active (hemi_blk=1, det_gate_off=1).
- R2: The hold-off lasts exactly CLK_HZ/1000*INHIBIT_MS clock cycles after reset and after every band change. While it lasts, hemi_blk, det_gate_off, band1_blk and band2_blk are all 1.
- R3: While the hold-off is active, sector_tick, sig_present and prf_done have no effect and sector_idx holds.
- R4: Outside the hold-off, a sector_tick with sig_present=0 advances sector_idx by one on that clock edge.
- R5: A sector_tick with sig_present=1 holds the sector. Further ticks are then ignored, and the sector advances on the edge where prf_done=1.
- R6: sector_idx wraps from NUM_SECTORS-1 to 0. Each wrap counts one full search.
- R7: With auto_avail=1, the wrap that completes search_cfg searches in the current band (search_cfg=0 counts as 1) toggles the band, resets sector_idx to 0 and starts the hold-off.
- R8: With auto_avail=0, man_band_vld=1 with man_band_sel different from the current band (0 selects band I, 1 selects band II) changes to that band on the next edge, resets the sector and starts the hold-off. Wraps never change the band in this mode.
- R9: With auto_avail=1, the manual band command has no effect.
- R10: blank_in=1 drives band1_blk and band2_blk to 1 in the same cycle, without an intervening register, and leaves sector and band unchanged.
- R11: Outside the hold-off and with blank_in=0, exactly one band enable is high. The block of the selected band is 0 and the block of the other band is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sector_tick | input | 1 | Sector-clock enable, one cycle per tick |
| sig_present | input | 1 | Current sector holds a signal |
| prf_done | input | 1 | Extra sector processing finished |
| blank_in | input | 1 | Radar blanking, forces receiver blocking |
| auto_avail | input | 1 | Automatic band control available |
| man_band_sel | input | 1 | Manual band: 0 = band I, 1 = band II |
| man_band_vld | input | 1 | Manual band command valid |
| search_cfg | input | SRCH_W | Full searches per band (0 acts as 1) |
| band1_en | output | 1 | Band I enabled |
| band2_en | output | 1 | Band II enabled |
| band1_blk | output | 1 | Band I blocked |
| band2_blk | output | 1 | Band II blocked |
| hemi_blk | output | 1 | Forward/rear hemisphere analysis blocked |
| det_gate_off | output | 1 | Pulse and CW detector inputs gated off |
| sector_idx | output | SEC_W | Current sector |

## Verification
Sector, band, enables and hold-off flags are registered. They change on the same clock edge that samples the causing tick, prf_done, wrap or manual command, so the bench compares them at the following falling edge. The hold-off length is measured at a scaled clock frequency, counting falling edges from reset release, and the count must equal exactly the derived cycle number. The band blocks also react to blank_in within the same cycle, so every comparison waits a short settling delay after the inputs are driven at the falling edge. It then checks against a reference model advanced at each rising edge.

// File: rtl/band_scan_pkg.sv
package band_scan_pkg;
  typedef enum logic {BAND_ONE = 1'b0, BAND_TWO = 1'b1} band_e;

  function automatic band_e other_band(input band_e b);
    return (b == BAND_ONE) ? BAND_TWO : BAND_ONE;
  endfunction
endpackage

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      active <= 1'b1;
      cnt_q  <= LOAD;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && cnt_q == LOAD));

  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (rst)
    (active && cnt_q != '0) |=> active);
endmodule

// File: rtl/sector_stepper.sv
module sector_stepper #(
  parameter int NUM_SECTORS = 8,
  parameter int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             restart,
  input  logic             tick,
  input  logic             present,
  input  logic             done,
  output logic [SEC_W-1:0] sector,
  output logic             wrap
);
  localparam logic [SEC_W-1:0] LAST = SEC_W'(NUM_SECTORS - 1);

  logic             busy_q;
  logic             advance;
  logic [SEC_W-1:0] next_sec;

  assign advance  = !hold && (busy_q ? done : (tick && !present));
  assign wrap     = advance && (sector == LAST);
  assign next_sec = (sector == LAST) ? '0 : sector + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sector <= '0;
      busy_q <= 1'b0;
    end else if (!hold) begin
      if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
          sector <= next_sec;
        end
      end else if (tick) begin
        if (present) busy_q <= 1'b1;
        else         sector <= next_sec;
      end
    end
  end

  // R3
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !restart) |=> $stable(sector));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done && !restart) |=> $stable(sector));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !busy_q && tick && !present && sector == LAST) |=> (sector == '0));
endmodule

// File: rtl/band_ctrl.sv
module band_ctrl
  import band_scan_pkg::*;
#(
  parameter int SRCH_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_ok,
  input  logic              wrap,
  input  logic [SRCH_W-1:0] cfg,
  input  logic              man_sel,
  input  logic              man_vld,
  output band_e             band,
  output logic              chg
);
  logic [SRCH_W-1:0] srch_q;
  logic [SRCH_W:0]   target;
  logic [SRCH_W:0]   done_cnt;
  logic              auto_chg;
  logic              man_chg;

  assign target   = (cfg == '0) ? (SRCH_W+1)'(1) : {1'b0, cfg};
  assign done_cnt = {1'b0, srch_q} + 1'b1;
  assign auto_chg = auto_ok && wrap && (done_cnt >= target);
  assign man_chg  = !auto_ok && man_vld && (band_e'(man_sel) != band);
  assign chg      = auto_chg || man_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      band   <= BAND_ONE;
      srch_q <= '0;
    end else if (chg) begin
      band   <= other_band(band);
      srch_q <= '0;
    end else if (auto_ok && wrap) begin
      srch_q <= srch_q + 1'b1;
    end
  end

  // R9
  auto_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_ok && !wrap) |=> $stable(band));

  // R8
  man_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_ok && man_vld) |=> (band == band_e'($past(man_sel))));
endmodule

// File: rtl/band_scan_seq.sv
module band_scan_seq
  import band_scan_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int INHIBIT_MS  = 40,
  parameter int NUM_SECTORS = 8,
  parameter int SRCH_W      = 3,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sector_tick,
  input  logic              sig_present,
  input  logic              prf_done,
  input  logic              blank_in,
  input  logic              auto_avail,
  input  logic              man_band_sel,
  input  logic              man_band_vld,
  input  logic [SRCH_W-1:0] search_cfg,
  output logic              band1_en,
  output logic              band2_en,
  output logic              band1_blk,
  output logic              band2_blk,
  output logic              hemi_blk,
  output logic              det_gate_off,
  output logic [SEC_W-1:0]  sector_idx
);
  localparam int INHIBIT_CYC = (CLK_HZ / 1000) * INHIBIT_MS;

  band_e band;
  logic  chg;
  logic  inh;
  logic  wrap;

  holdoff_timer #(.CYCLES(INHIBIT_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (chg),
    .active (inh)
  );

  sector_stepper #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_step (
    .clk     (clk),
    .rst     (rst),
    .hold    (inh),
    .restart (chg),
    .tick    (sector_tick),
    .present (sig_present),
    .done    (prf_done),
    .sector  (sector_idx),
    .wrap    (wrap)
  );

  band_ctrl #(.SRCH_W(SRCH_W)) u_band (
    .clk     (clk),
    .rst     (rst),
    .auto_ok (auto_avail),
    .wrap    (wrap),
    .cfg     (search_cfg),
    .man_sel (man_band_sel),
    .man_vld (man_band_vld),
    .band    (band),
    .chg     (chg)
  );

  assign band1_en     = (band == BAND_ONE);
  assign band2_en     = (band == BAND_TWO);
  assign hemi_blk     = inh;
  assign det_gate_off = inh;
  assign band1_blk    = blank_in || inh || (band != BAND_ONE);
  assign band2_blk    = blank_in || inh || (band != BAND_TWO);

  // R10
  blank_force_chk: assert property (@(posedge clk) disable iff (rst)
    blank_in |-> (band1_blk && band2_blk));

  // R11
  one_open_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_in && !hemi_blk) |-> (band1_blk != band2_blk));

  // R2
  chg_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    chg |=> (hemi_blk && det_gate_off && sector_idx == '0));
endmodule

// File: tb/tb_band_scan_seq.sv
module tb_band_scan_seq;
  localparam int CLK_HZ = 50_000;
  localparam int INH_MS = 40;
  localparam int NSEC   = 8;
  localparam int SW     = 3;
  localparam int SECW   = 3;
  localparam int INH    = (CLK_HZ / 1000) * INH_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sector_tick = 0, sig_present = 0, prf_done = 0, blank_in = 0;
  logic auto_avail = 1, man_band_sel = 0, man_band_vld = 0;
  logic [SW-1:0] search_cfg = 3'd1;
  logic band1_en, band2_en, band1_blk, band2_blk, hemi_blk, det_gate_off;
  logic [SECW-1:0] sector_idx;

  int checks = 0, fails = 0, cyc = 0;
  bit done_flag = 0;

  // reference model state
  int m_band = 0, m_sec = 0, m_busy = 0, m_srch = 0, m_inh = 1, m_cnt = INH - 1;

  always #10 clk = ~clk;

  band_scan_seq #(.CLK_HZ(CLK_HZ), .INHIBIT_MS(INH_MS), .NUM_SECTORS(NSEC),
                  .SRCH_W(SW), .SEC_W(SECW)) dut (
    .clk(clk), .rst(rst), .sector_tick(sector_tick), .sig_present(sig_present),
    .prf_done(prf_done), .blank_in(blank_in), .auto_avail(auto_avail),
    .man_band_sel(man_band_sel), .man_band_vld(man_band_vld), .search_cfg(search_cfg),
    .band1_en(band1_en), .band2_en(band2_en), .band1_blk(band1_blk), .band2_blk(band2_blk),
    .hemi_blk(hemi_blk), .det_gate_off(det_gate_off), .sector_idx(sector_idx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_sec(input int s);
    return (s == NSEC - 1) ? 0 : s + 1;
  endfunction

  function automatic int target_of(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  // reference model, advanced from the inputs seen at each rising edge
  always @(posedge clk) begin
    int adv, wr, chg, n_sec, n_busy, n_band, n_srch, n_inh, n_cnt;
    if (rst) begin
      m_band = 0; m_sec = 0; m_busy = 0; m_srch = 0; m_inh = 1; m_cnt = INH - 1;
    end else begin
      adv = (!m_inh && (m_busy ? prf_done : (sector_tick && !sig_present))) ? 1 : 0;
      wr  = (adv && m_sec == NSEC - 1) ? 1 : 0;
      chg = ((auto_avail && wr && (m_srch + 1 >= target_of(int'(search_cfg)))) ||
             (!auto_avail && man_band_vld && int'(man_band_sel) != m_band)) ? 1 : 0;
      n_sec = m_sec; n_busy = m_busy; n_band = m_band; n_srch = m_srch;
      n_inh = m_inh; n_cnt = m_cnt;
      if (chg) begin
        n_inh = 1; n_cnt = INH - 1; n_sec = 0; n_busy = 0;
        n_band = 1 - m_band; n_srch = 0;
      end else begin
        if (m_inh) begin
          if (m_cnt == 0) n_inh = 0; else n_cnt = m_cnt - 1;
        end else if (m_busy) begin
          if (prf_done) begin n_busy = 0; n_sec = next_sec(m_sec); end
        end else if (sector_tick) begin
          if (sig_present) n_busy = 1; else n_sec = next_sec(m_sec);
        end
        if (auto_avail && wr) n_srch = m_srch + 1;
      end
      m_sec = n_sec; m_busy = n_busy; m_band = n_band; m_srch = n_srch;
      m_inh = n_inh; m_cnt = n_cnt;
    end
  end

  // compare outputs against the model after inputs have settled
  always @(negedge clk) begin
    #2;
    if (!done_flag) begin
      chk(int'(sector_idx) == m_sec, "R3 R4 R5 R6 sector", int'(sector_idx), m_sec);
      chk(int'(band2_en) == m_band && band1_en == !band2_en, "R7 R8 R9 R11 band",
          int'(band2_en), m_band);
      chk(int'(hemi_blk) == m_inh && det_gate_off == hemi_blk, "R2 holdoff",
          int'(hemi_blk), m_inh);
      chk(int'(band1_blk) == (blank_in || m_inh || m_band == 1), "R10 R11 band1_blk",
          int'(band1_blk), int'(blank_in || m_inh || m_band == 1));
      chk(int'(band2_blk) == (blank_in || m_inh || m_band == 0), "R10 R11 band2_blk",
          int'(band2_blk), int'(blank_in || m_inh || m_band == 0));
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic pulse_tick(input bit pres);
    @(negedge clk); sector_tick = 1; sig_present = pres;
    @(negedge clk); sector_tick = 0; sig_present = 0;
  endtask

  task automatic rand_phase(input int n, input int man_rate);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sector_tick  = ($urandom_range(0, 3) == 0);
      sig_present  = ($urandom_range(0, 9) < 3);
      prf_done     = ($urandom_range(0, 4) == 0);
      blank_in     = ($urandom_range(0, 9) == 0);
      man_band_vld = ($urandom_range(0, man_rate - 1) == 0);
      man_band_sel = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    sector_tick = 0; sig_present = 0; prf_done = 0; blank_in = 0; man_band_vld = 0;
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(band1_en && !band2_en, "R1 band", int'(band2_en), 0);
    chk(sector_idx == 0, "R1 sector", int'(sector_idx), 0);
    chk(hemi_blk && det_gate_off, "R1 holdoff", int'(hemi_blk), 1);

    // R2: exact hold-off length after reset release; ticks during it are ignored (R3)
    @(negedge clk); rst = 0;
    n = 0;
    while (hemi_blk && n < INH + 10) begin
      n++;
      sector_tick = (n % 3 == 0);
      @(negedge clk);
    end
    sector_tick = 0;
    chk(n == INH, "R2 holdoff length", n, INH);
    chk(sector_idx == 0, "R3 sector frozen", int'(sector_idx), 0);

    // R4: empty sector advances
    pulse_tick(0);
    chk(sector_idx == 1, "R4 advance", int'(sector_idx), 1);
    // R5: occupied sector holds, extra tick ignored, prf_done advances
    pulse_tick(1);
    chk(sector_idx == 1, "R5 hold", int'(sector_idx), 1);
    pulse_tick(0);
    chk(sector_idx == 1, "R5 tick ignored while busy", int'(sector_idx), 1);
    @(negedge clk); prf_done = 1;
    @(negedge clk); prf_done = 0;
    chk(sector_idx == 2, "R5 advance on done", int'(sector_idx), 2);

    // R10: blanking forces both blocks at once, scan state untouched
    chk(!band1_blk && band2_blk, "R11 open band", int'(band1_blk), 0);
    @(negedge clk); blank_in = 1; #2;
    chk(band1_blk && band2_blk, "R10 blank", int'(band1_blk), 1);
    @(negedge clk); blank_in = 0;
    chk(sector_idx == 2 && band1_en, "R10 state kept", int'(sector_idx), 2);

    // R9: manual command ignored in auto mode
    @(negedge clk); man_band_vld = 1; man_band_sel = 1;
    @(negedge clk); man_band_vld = 0;
    chk(band1_en && !hemi_blk, "R9 manual ignored", int'(band2_en), 0);

    // R6/R7: search_cfg=1, the wrap after sector 7 changes band
    for (int k = 0; k < 5; k++) pulse_tick(0);
    chk(sector_idx == 7 && band1_en, "R6 last sector", int'(sector_idx), 7);
    pulse_tick(0);
    chk(band2_en && sector_idx == 0 && hemi_blk, "R7 band change", int'(band2_en), 1);

    // R8: manual mode back to band I
    @(negedge clk); auto_avail = 0; man_band_vld = 1; man_band_sel = 0;
    @(negedge clk); man_band_vld = 0;
    chk(band1_en && hemi_blk, "R8 manual change", int'(band1_en), 1);

    // random phases checked by the model
    auto_avail = 1; search_cfg = 3'd0;
    rand_phase(12000, 50);
    search_cfg = 3'd3;
    rand_phase(25000, 50);
    auto_avail = 0;
    rand_phase(15000, 2500);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule